// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading translation entries from memory. A request carries the linear address and a read/write access type. The walker fetches the first-level (directory) entry at an address formed from the directory base frame and the top ten address bits. If that entry maps a large 4 MB page, the walk stops there. Otherwise the walker fetches a second-level (table) entry and forms the address of a 4 KB page. A missing mapping at either level ends the walk with a fault response in place of an address.

Every entry the walker uses gets its accessed flag set, so that software can clear the flags from time to time and approximate least-recently-used replacement. The flag is stored back through a read-modify-write on the same memory port. The write happens only when the stored entry actually changes. A write access also marks the final entry of the walk as dirty. The walker handles one request at a time.

Top module: `pgw_top`

## Requirements
- R1: In reset and on the first cycle after it, `req_ready` is 1 and `resp_valid` and `mem_req` are 0.
- R2: The directory entry is read from byte address `{dir_base, laddr[31:22], 2'b00}`, which is the base plus four times the directory index.
- R3: When the directory entry has bit 0 (present) set and bit 7 (size) clear, the table entry is read from `{pde[31:12], laddr[21:12], 2'b00}`. The result is `{pte[31:12], laddr[11:0]}`.
- R4: When the directory entry has bit 0 and bit 7 set, the result is `{pde[31:22], laddr[21:0]}` and no second read is made.
- R5: When directory entry bit 0 is clear, the response has `resp_fault`=1 and `resp_paddr`=0. Only one read is made and nothing is written.
- R6: When the table entry has bit 0 clear, the response has `resp_fault`=1 and `resp_paddr`=0, and the table entry is not written.
- R7: Each present entry that is used gets bit 5 (accessed) set. It is written back to the address it was read from only if the value changes. All other bits are kept unchanged.
- R8: On a write access (`req_write`=1) the final entry also gets bit 6 (dirty) set. The final entry is the table entry, or the directory entry of a 4 MB page. A directory entry that points to a table never gets bit 6 set by the walker.
- R9: One walk runs at a time. `req_ready` drops the cycle after a request is accepted, and `req_valid` is ignored until the walk ends. `resp_valid` is a one-cycle pulse, followed by `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 20 | Frame number of the directory (4 KB aligned), sampled at request |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access type: 1 = write, 0 = read |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Page fault (non-present entry) |
| resp_paddr | output | 32 | Physical address, zero on fault |
| mem_req | output | 1 | Memory access strobe, one cycle per access |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for a write |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data |

## Verification
The memory model answers each read after one to three cycles, so the walk length varies. For that reason the bench waits for `resp_valid` instead of counting cycles. `req_ready` must be low on the first falling edge after acceptance. The response fields are sampled on the falling edge where `resp_valid` is seen. A write-back issued in the last step of a walk is visible to memory during the response cycle and is captured on the edge that ends it. The write log, the pulse end of `resp_valid` and the return of `req_ready` are therefore checked one cycle after the response. The read-address log is compared with the expected entry addresses for each level.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int PRES_BIT  = 0;
  localparam int ACC_BIT   = 5;
  localparam int DIRTY_BIT = 6;
  localparam int BIG_BIT   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_CHK_DIR,
    ST_NXT_DIR,
    ST_RD_TBL,
    ST_CHK_TBL,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-OFF_W-1:0] base_frame,
  input  logic [ADDR_W-1:0]       laddr,
  input  logic [ADDR_W-OFF_W-1:0] pde_frame,
  input  logic [ADDR_W-OFF_W-1:0] pte_frame,
  output logic [ADDR_W-1:0]       dir_ea,
  output logic [ADDR_W-1:0]       tbl_ea,
  output logic [ADDR_W-1:0]       pa_small,
  output logic [ADDR_W-1:0]       pa_big
);
  localparam int BIG_OFF_W = IDX_W + OFF_W;
  localparam int FR_W      = ADDR_W - OFF_W;
  localparam int BIG_FR_W  = ADDR_W - BIG_OFF_W;

  always_comb begin
    dir_ea   = {base_frame, laddr[ADDR_W-1 -: IDX_W], 2'b00};
    tbl_ea   = {pde_frame, laddr[BIG_OFF_W-1:OFF_W], 2'b00};
    pa_small = {pte_frame, laddr[OFF_W-1:0]};
    pa_big   = {pde_frame[FR_W-1 -: BIG_FR_W], laddr[BIG_OFF_W-1:0]};
  end
endmodule

// File: rtl/pgw_entry.sv
module pgw_entry #(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             leaf,
  input  logic             wr,
  output logic             present,
  output logic             big,
  output logic [ENT_W-1:0] upd,
  output logic             need_wb
);
  import pgw_pkg::*;

  always_comb begin
    present = entry[PRES_BIT];
    big     = entry[BIG_BIT];
    upd     = entry;
    upd[ACC_BIT] = 1'b1;
    if (leaf && wr) upd[DIRTY_BIT] = 1'b1;
    need_wb = present && (upd != entry);
  end
endmodule

// File: rtl/pgw_top.sv
module pgw_top #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-OFF_W-1:0] dir_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_laddr,
  input  logic                    req_write,
  output logic                    resp_valid,
  output logic                    resp_fault,
  output logic [ADDR_W-1:0]       resp_paddr,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_wdata,
  input  logic                    mem_rvalid,
  input  logic [ADDR_W-1:0]       mem_rdata
);
  import pgw_pkg::*;

  localparam int LEVELS = 2;
  localparam int FR_W   = ADDR_W - OFF_W;
  localparam int LV_DIR = 0;
  localparam int LV_TBL = LEVELS - 1;

  walk_st_e          st;
  logic [ADDR_W-1:0] la_q;
  logic              wr_q;
  logic [ADDR_W-1:0] ent_q [LEVELS];

  logic [LEVELS-1:0] ent_pres, ent_big, ent_wb;
  logic [ADDR_W-1:0] ent_upd [LEVELS];

  logic [ADDR_W-1:0] la_sel, dir_ea, tbl_ea, pa_small, pa_big;

  assign la_sel    = (st == ST_IDLE) ? req_laddr : la_q;
  assign req_ready = (st == ST_IDLE);

  pgw_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .base_frame (dir_base),
    .laddr      (la_sel),
    .pde_frame  (ent_q[LV_DIR][ADDR_W-1 -: FR_W]),
    .pte_frame  (ent_q[LV_TBL][ADDR_W-1 -: FR_W]),
    .dir_ea     (dir_ea),
    .tbl_ea     (tbl_ea),
    .pa_small   (pa_small),
    .pa_big     (pa_big)
  );

  // One decoder per level; the last level is always the leaf, a directory
  // entry is a leaf only when it maps a large page.
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    logic leaf;
    if (lv == LEVELS - 1) begin : g_leaf
      assign leaf = 1'b1;
    end else begin : g_inner
      assign leaf = ent_q[lv][BIG_BIT];
    end
    pgw_entry #(.ENT_W(ADDR_W)) u_ent (
      .entry   (ent_q[lv]),
      .leaf    (leaf),
      .wr      (wr_q),
      .present (ent_pres[lv]),
      .big     (ent_big[lv]),
      .upd     (ent_upd[lv]),
      .need_wb (ent_wb[lv])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      la_q       <= '0;
      wr_q       <= 1'b0;
      ent_q[0]   <= '0;
      ent_q[1]   <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          resp_valid <= 1'b0;
          if (req_valid) begin
            la_q     <= req_laddr;
            wr_q     <= req_write;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= dir_ea;
            st       <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          if (mem_rvalid) begin
            ent_q[LV_DIR] <= mem_rdata;
            st            <= ST_CHK_DIR;
          end
        end
        ST_CHK_DIR: begin
          if (!ent_pres[LV_DIR]) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            st         <= ST_DONE;
          end else begin
            if (ent_wb[LV_DIR]) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= ent_upd[LV_DIR];
            end
            if (ent_big[LV_DIR]) begin
              resp_valid <= 1'b1;
              resp_fault <= 1'b0;
              resp_paddr <= pa_big;
              st         <= ST_DONE;
            end else begin
              st <= ST_NXT_DIR;
            end
          end
        end
        ST_NXT_DIR: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= tbl_ea;
          st       <= ST_RD_TBL;
        end
        ST_RD_TBL: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          if (mem_rvalid) begin
            ent_q[LV_TBL] <= mem_rdata;
            st            <= ST_CHK_TBL;
          end
        end
        ST_CHK_TBL: begin
          resp_valid <= 1'b1;
          st         <= ST_DONE;
          if (!ent_pres[LV_TBL]) begin
            resp_fault <= 1'b1;
            resp_paddr <= '0;
          end else begin
            resp_fault <= 1'b0;
            resp_paddr <= pa_small;
            if (ent_wb[LV_TBL]) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= ent_upd[LV_TBL];
            end
          end
        end
        ST_DONE: begin
          mem_req    <= 1'b0;
          mem_we     <= 1'b0;
          resp_valid <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_fault,
  input logic [ADDR_W-1:0] resp_paddr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wb_acc
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (req_ready && !resp_valid && !mem_req));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> (!resp_valid && req_ready));

  // R5 and R6: a fault never carries an address
  p_fault_no_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));

  p_wb_accessed_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> wb_acc);

  p_wb_same_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> $stable(mem_addr));
endmodule

bind pgw_top pgw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_fault (resp_fault),
  .resp_paddr (resp_paddr),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .wb_acc     (mem_wdata[pgw_pkg::ACC_BIT])
);

// File: tb/tb_pgw_top.sv
module tb_pgw_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] dir_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        req_write = 1'b0;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  pgw_top dut (
    .clk(clk), .rst(rst), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_write(req_write),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Memory model: 32 KB, reads answered after lat_cfg cycles
  logic [31:0] mem [8192];
  int          lat_cfg = 1;
  logic        clr_log = 1'b0;
  logic [31:0] raddr = '0;
  int          dly = 0;
  int          rcnt = 0, wcnt = 0;
  logic [31:0] rlog [2];
  logic [31:0] wlog_a [2];
  logic [31:0] wlog_d [2];

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      dly  <= 0;
      rcnt <= 0;
      wcnt <= 0;
    end else begin
      if (mem_req && !mem_we) begin
        raddr <= mem_addr;
        dly   <= lat_cfg;
        if (rcnt < 2) rlog[rcnt] <= mem_addr;
        rcnt <= rcnt + 1;
      end else if (dly != 0) begin
        dly <= dly - 1;
        if (dly == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[raddr[14:2]];
        end
      end
      if (mem_req && mem_we) begin
        if (wcnt < 2) begin
          wlog_a[wcnt] <= mem_addr;
          wlog_d[wcnt] <= mem_wdata;
        end
        wcnt <= wcnt + 1;
      end
      if (clr_log) begin
        rcnt <= 0;
        wcnt <= 0;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] upd_f(input logic [31:0] e, input bit leaf, input bit wr);
    logic [31:0] r;
    r = e | 32'h20;
    if (leaf && wr) r = r | 32'h40;
    return r;
  endfunction

  task automatic run_walk(input logic [19:0] bfr, input logic [31:0] la, input bit wr,
                          input logic [31:0] pde, input logic [31:0] pte, input int lat,
                          input bit poke);
    logic [31:0] dea, tea, e_pa, e_pde, e_pte;
    logic [31:0] ea [2];
    logic [31:0] ed [2];
    bit e_f, d_f;
    int e_rd, e_wr, wt;
    dea = {bfr, la[31:22], 2'b00};
    tea = {pde[31:12], la[21:12], 2'b00};
    mem[dea[14:2]] = pde;
    if (pde[0] && !pde[7]) mem[tea[14:2]] = pte;
    e_wr = 0; e_rd = 1; e_f = 0; d_f = 0; e_pa = '0;
    ea[0] = '0; ea[1] = '0; ed[0] = '0; ed[1] = '0;
    if (!pde[0]) begin
      e_f = 1; d_f = 1;
    end else begin
      e_pde = upd_f(pde, pde[7], wr);
      if (e_pde != pde) begin ea[e_wr] = dea; ed[e_wr] = e_pde; e_wr++; end
      if (pde[7]) e_pa = {pde[31:22], la[21:0]};
      else begin
        e_rd = 2;
        if (!pte[0]) e_f = 1;
        else begin
          e_pte = upd_f(pte, 1'b1, wr);
          if (e_pte != pte) begin ea[e_wr] = tea; ed[e_wr] = e_pte; e_wr++; end
          e_pa = {pte[31:12], la[11:0]};
        end
      end
    end

    @(negedge clk);
    dir_base = bfr; req_laddr = la; req_write = wr; req_valid = 1'b1;
    lat_cfg = lat; clr_log = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; clr_log = 1'b0;
    chk(!req_ready, "R9 ready low after accept", {31'b0, req_ready}, 32'h0);
    if (poke) begin
      req_valid = 1'b1; req_laddr = ~la; req_write = !wr;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wt = 0;
    while (!resp_valid && wt < 200) begin @(negedge clk); wt++; end
    chk(resp_valid, "R9 response arrives", {31'b0, resp_valid}, 32'h1);
    chk(resp_fault == e_f, d_f ? "R5 fault flag" : "R6 fault flag", {31'b0, resp_fault}, {31'b0, e_f});
    chk(resp_paddr == e_pa, e_f ? "R5,R6 fault address zero" : (pde[7] ? "R4 large page address" : "R3 small page address"),
        resp_paddr, e_pa);
    chk(rlog[0] == dea, "R2 directory entry address", rlog[0], dea);
    chk(rcnt == e_rd, "R4,R5 read count", rcnt, e_rd);
    if (e_rd == 2) chk(rlog[1] == tea, "R3 table entry address", rlog[1], tea);
    @(negedge clk);
    chk(!resp_valid && req_ready, "R9 pulse ends and ready returns", {30'b0, resp_valid, req_ready}, 32'h1);
    chk(wcnt == e_wr, "R7 write-back count", wcnt, e_wr);
    for (int i = 0; i < 2; i++) begin
      if (i < e_wr && i < wcnt) begin
        chk(wlog_a[i] == ea[i], "R7 write-back address", wlog_a[i], ea[i]);
        chk(wlog_d[i] == ed[i], "R7,R8 write-back data", wlog_d[i], ed[i]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r, pde, pte;
    int k;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8192; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1 reset state", {29'b0, req_ready, resp_valid, mem_req}, 32'h4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1 after reset", {29'b0, req_ready, resp_valid, mem_req}, 32'h4);

    // R3 R7: small page read, both accessed flags clear -> two write-backs
    run_walk(20'h0, 32'h1234_5678, 1'b0, 32'h0000_1001, 32'hABCD_E001, 1, 1'b0);
    // R8: small page write, flags already set -> no write-back
    run_walk(20'h4, 32'hFFC0_1ABC, 1'b1, 32'h0000_2021, 32'h5555_5061, 2, 1'b0);
    // R8: small page write, pte dirty clear -> pte written with dirty, pde accessed only
    run_walk(20'h0, 32'h0040_3FFF, 1'b1, 32'h0000_3001, 32'h0001_0021, 3, 1'b0);
    // R4 R8: large page write, accessed set, dirty clear
    run_walk(20'h0, 32'hC03F_FFFF, 1'b1, 32'hFFC0_00A1, 32'h0, 1, 1'b0);
    // R4: large page read, all flags set
    run_walk(20'h4, 32'h0000_0000, 1'b0, 32'h0040_00E1, 32'h0, 2, 1'b0);
    // R5: directory entry not present
    run_walk(20'h0, 32'h8000_0000, 1'b1, 32'hFFFF_FFFE, 32'h0, 1, 1'b0);
    // R6: table entry not present
    run_walk(20'h4, 32'h7FFF_FFFF, 1'b0, 32'h0000_1001, 32'hFFFF_FFFE, 2, 1'b0);
    // R9: request pulsed while busy is ignored
    run_walk(20'h0, 32'h0123_4567, 1'b0, 32'h0000_2001, 32'h0BAD_0001, 3, 1'b1);

    for (int n = 0; n < 300; n++) begin
      k = $urandom % 4;
      r = $urandom;
      case (k)
        0: pde = r & ~32'h1;
        1: pde = r | 32'h81;
        default: begin
          pde = {20'(1 + $urandom % 3), r[11:0]};
          pde[0] = 1'b1;
          pde[7] = 1'b0;
        end
      endcase
      pte = $urandom;
      pte[0] = ($urandom % 5) != 0;
      run_walk(($urandom % 2) ? 20'h4 : 20'h0, $urandom, 1'($urandom % 2), pde, pte,
               1 + $urandom % 3, 1'(($urandom % 8) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule